// File: doc/BRIEF.md
# Thirty-two pin I/O port with per-pin interrupt detection

The block is a 32-pin general-purpose I/O port on a simple 16-bit register bus. Each pin carries a direction bit and a data bit. A pin set as output drives its data bit. A pin set as input is read back through a synchronizer. The pins fall into a low half (0 to 15) and a high half (16 to 31), and every per-pin register comes as a pair of 16-bit words, one for each half.

Each pin has an event detector with four per-pin settings:
- level or edge trigger;
- which level is active;
- separate enables for the rising edge and the falling edge;
- sticky (hold) capture or follow-the-detector (through) capture.

Detected events land in write-one-to-clear status bits. A status bit only raises the single interrupt request when its enable bit is also set. Along with the request, the block reports the index of the lowest-numbered pending, enabled pin, so the handler can dispatch without scanning the status words.

The bus address `reg_addr` is a halfword index, equal to the byte offset divided by two. Within a register pair, bit 0 of the index selects the half, and the upper four bits select the register.

Top module: `pio_irq_unit`

## Requirements
- R1: While reset is held, every register reads zero, `pin_oe` is all zero, and `irq` and `irq_valid` are low.
- R2: A direction bit of 1 drives `pin_oe` high and `pin_out` from that pin's data bit. Reading the data pair (byte offsets 0x04/0x06) returns the data bit for output pins and the synchronized pin level for input pins. The direction pair sits at 0x00/0x02.
- R3: With the trigger-type bit (0x10/0x12) at 0, detection is on level. The active level is high when the level-select bit (0x14/0x16) is 1 and low when it is 0.
- R4: With the trigger-type bit at 1, detection is on edges. A rising-edge bit (0x24/0x26) enables detection of 0-to-1 transitions, and a falling-edge bit (0x20/0x22) enables detection of 1-to-0 transitions. Both bits set detects either edge; neither bit set detects nothing.
- R5: With the hold-select bit (0x18/0x1A) at 1, a detected event sets the status bit and the bit stays set until it is cleared. With the bit at 0, the status bit takes the detector output every cycle, so an edge gives a one-cycle status pulse.
- R6: Writing the status pair (0x08/0x0A) clears each status bit written as 1 and leaves each bit written as 0 unchanged. A detection in the same cycle as the clear wins.
- R7: A pin change is first visible in its status bit after the third rising clock edge following the change, and not after the second.
- R8: `irq` and `irq_valid` are high exactly when some pin has both its status bit and its enable bit (0x0C/0x0E) set. `irq_pin` is then the lowest such pin number; low-half pins come before high-half pins.
- R9: All configuration pairs read back the value last written. Unmapped offsets (for example 0x1C) read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 5 | Halfword register index (byte offset / 2) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output values (data register) |
| pin_oe | output | 32 | Output enables (direction register) |
| irq | output | 1 | Combined interrupt request |
| irq_valid | output | 1 | `irq_pin` holds a pending, enabled pin |
| irq_pin | output | 5 | Lowest pending, enabled pin number |

## Verification
Each result has its own latency:
- Register writes take effect at the clock edge that samples the strobe.
- Read data and the interrupt outputs follow combinationally from the registers.
- An input level reaches the data readback two edges after it changes.
- An input change reaches the status bits three edges after it changes.

The bench drives all stimulus on the falling clock edge. It counts exactly the required number of rising edges and samples on the next falling edge. The latency check for R7 samples once after two edges, expecting no event, and again after three, expecting the event. In through mode the one-cycle edge pulse is caught in the single sampling window where it exists, and a later sample confirms that it has gone.

// File: rtl/pio_irq_pkg.sv
package pio_irq_pkg;

  localparam int HALF_W = 16;
  localparam int N_PINS = 2 * HALF_W;
  localparam int IDX_W  = $clog2(N_PINS);

  // register selector = halfword index [4:1]; index bit 0 picks the half
  typedef enum logic [3:0] {
    RG_DIR  = 4'd0,
    RG_DATA = 4'd1,
    RG_STAT = 4'd2,
    RG_EN   = 4'd3,
    RG_TYPE = 4'd4,
    RG_LVL  = 4'd5,
    RG_HOLD = 4'd6,
    RG_FALL = 4'd8,
    RG_RISE = 4'd9
  } reg_sel_e;

  function automatic logic [N_PINS-1:0] merge_half(
    input logic [N_PINS-1:0] old_v,
    input logic              upper,
    input logic [HALF_W-1:0] word
  );
    return upper ? {word, old_v[HALF_W-1:0]} : {old_v[N_PINS-1:HALF_W], word};
  endfunction

  function automatic logic [HALF_W-1:0] pick_half(
    input logic [N_PINS-1:0] v,
    input logic              upper
  );
    return upper ? v[N_PINS-1:HALF_W] : v[HALF_W-1:0];
  endfunction

  function automatic logic detect_event(
    input logic edge_mode,
    input logic act_high,
    input logic fall_en,
    input logic rise_en,
    input logic prev,
    input logic now
  );
    logic rose, fell;
    rose = now & ~prev;
    fell = prev & ~now;
    if (edge_mode) return (rise_en & rose) | (fall_en & fell);
    return now == act_high;
  endfunction

  function automatic logic next_status(
    input logic cur,
    input logic hold,
    input logic clr,
    input logic det
  );
    // a detection in the clear cycle wins so no event is lost
    return hold ? ((cur & ~clr) | det) : det;
  endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pio_pin_detect.sv
module pio_pin_detect
  import pio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s_in,
  input  logic edge_mode,
  input  logic act_high,
  input  logic hold,
  input  logic fall_en,
  input  logic rise_en,
  input  logic clr,
  output logic det_o,
  output logic status_o
);
  logic prev_q;

  assign det_o = detect_event(edge_mode, act_high, fall_en, rise_en, prev_q, s_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      status_o <= 1'b0;
    end else begin
      prev_q   <= s_in;
      status_o <= next_status(status_o, hold, clr, det_o);
    end
  end

  assert_hold_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && status_o && !clr) |=> status_o);

  assert_through_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (status_o == $past(det_o)));

  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !det_o) |=> !status_o);

  assert_rise_seen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && rise_en && $rose(s_in)) |-> det_o);

  assert_fall_seen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && fall_en && $fell(s_in)) |-> det_o);
endmodule

// File: rtl/pio_prio_enc.sv
module pio_prio_enc #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  pend_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IW'(i);
    end
  end

  assign valid_o = |pend_i;
endmodule

// File: rtl/pio_irq_unit.sv
module pio_irq_unit
  import pio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [4:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_out,
  output logic [31:0]       pin_oe,
  output logic              irq,
  output logic              irq_valid,
  output logic [4:0]        irq_pin
);
  logic [N_PINS-1:0] dir_q, dat_q, en_q, typ_q, lvl_q, hld_q, fal_q, ris_q;
  logic [N_PINS-1:0] pin_s, det_vec, stat_vec, clr_vec, pend, rd_vec, din_view;
  reg_sel_e          sel;
  logic              upper;

  assign sel   = reg_sel_e'(reg_addr[4:1]);
  assign upper = reg_addr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0; dat_q <= '0; en_q  <= '0; typ_q <= '0;
      lvl_q <= '0; hld_q <= '0; fal_q <= '0; ris_q <= '0;
    end else if (reg_wr) begin
      case (sel)
        RG_DIR:  dir_q <= merge_half(dir_q, upper, reg_wdata);
        RG_DATA: dat_q <= merge_half(dat_q, upper, reg_wdata);
        RG_EN:   en_q  <= merge_half(en_q,  upper, reg_wdata);
        RG_TYPE: typ_q <= merge_half(typ_q, upper, reg_wdata);
        RG_LVL:  lvl_q <= merge_half(lvl_q, upper, reg_wdata);
        RG_HOLD: hld_q <= merge_half(hld_q, upper, reg_wdata);
        RG_FALL: fal_q <= merge_half(fal_q, upper, reg_wdata);
        RG_RISE: ris_q <= merge_half(ris_q, upper, reg_wdata);
        default: ;
      endcase
    end
  end

  assign clr_vec = (reg_wr && sel == RG_STAT) ? merge_half('0, upper, reg_wdata) : '0;

  pio_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_in), .q_o(pin_s)
  );

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    pio_pin_detect u_det (
      .clk(clk), .rst_n(rst_n), .s_in(pin_s[p]),
      .edge_mode(typ_q[p]), .act_high(lvl_q[p]), .hold(hld_q[p]),
      .fall_en(fal_q[p]), .rise_en(ris_q[p]), .clr(clr_vec[p]),
      .det_o(det_vec[p]), .status_o(stat_vec[p])
    );
  end

  assign pend = stat_vec & en_q;

  pio_prio_enc #(.W(N_PINS), .IW(IDX_W)) u_enc (
    .pend_i(pend), .valid_o(irq_valid), .idx_o(irq_pin)
  );

  assign irq     = irq_valid;
  assign pin_out = dat_q;
  assign pin_oe  = dir_q;

  assign din_view = (dat_q & dir_q) | (pin_s & ~dir_q);

  always_comb begin
    case (sel)
      RG_DIR:  rd_vec = dir_q;
      RG_DATA: rd_vec = din_view;
      RG_STAT: rd_vec = stat_vec;
      RG_EN:   rd_vec = en_q;
      RG_TYPE: rd_vec = typ_q;
      RG_LVL:  rd_vec = lvl_q;
      RG_HOLD: rd_vec = hld_q;
      RG_FALL: rd_vec = fal_q;
      RG_RISE: rd_vec = ris_q;
      default: rd_vec = '0;
    endcase
  end

  assign reg_rdata = pick_half(rd_vec, upper);

  assert_idx_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (stat_vec[irq_pin] && en_q[irq_pin]));

  assert_idx_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((pend & ((32'd1 << irq_pin) - 32'd1)) == '0));

  assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == RG_DATA && !upper) |=> (pin_out[HALF_W-1:0] == $past(reg_wdata)));

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == RG_DIR && upper) |=> (pin_oe[N_PINS-1:HALF_W] == $past(reg_wdata)));
endmodule

// File: tb/pio_irq_unit_tb.sv
`timescale 1ns/100ps
module pio_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq, irq_valid;
  logic [4:0]  irq_pin;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  pio_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .irq_valid(irq_valid),
    .irq_pin(irq_pin)
  );

  // byte offsets of the register pairs (low half; high half is +2)
  localparam logic [5:0] OF_DIR = 6'h00, OF_DATA = 6'h04, OF_STAT = 6'h08, OF_EN = 6'h0C;
  localparam logic [5:0] OF_TYPE = 6'h10, OF_LVL = 6'h14, OF_HOLD = 6'h18;
  localparam logic [5:0] OF_FALL = 6'h20, OF_RISE = 6'h24;

  // {pin[4:0], type, lvl, hold, fall, rise, v0, v1, exp_now, exp_late}
  localparam int NV = 10;
  localparam logic [13:0] VEC [0:NV-1] = '{
    {5'd3,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R3 high level, hold
    {5'd3,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R3 low level, through
    {5'd20, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 rise, through pulse
    {5'd20, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R5 rise, hold
    {5'd7,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R4 fall only
    {5'd7,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 rise only, falling input
    {5'd31, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R4 both edges
    {5'd16, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R3 high level, through
    {5'd0,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 fall only, rising input
    {5'd11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}  // R4 no edge bit
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] ofs, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ofs[5:1]; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] ofs, output logic [15:0] d);
    reg_addr = ofs[5:1];
    #0.5;
    d = reg_rdata;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run still busy, expected completion");
      report();
    end
  end

  initial begin
    logic [15:0] rd;
    // R1: reset state
    repeat (3) @(negedge clk);
    for (int o = 0; o < 40; o += 2) begin
      bus_rd(6'(o), rd);
      check($sformatf("R1 reset read 0x%0h", o), 32'(rd), 32'h0);
    end
    check("R1 reset pin_oe", pin_oe, 32'h0);
    check("R1 reset irq", {31'd0, irq}, 32'h0);
    check("R1 reset irq_valid", {31'd0, irq_valid}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R9: read back of configuration, unmapped offset
    bus_wr(OF_LVL, 16'h1234);
    bus_wr(OF_RISE + 6'd2, 16'hBEEF);
    bus_wr(OF_HOLD + 6'd2, 16'h0F0F);
    bus_rd(OF_LVL, rd);          check("R9 level low readback", 32'(rd), 32'h1234);
    bus_rd(OF_RISE + 6'd2, rd);  check("R9 rise high readback", 32'(rd), 32'hBEEF);
    bus_rd(OF_HOLD + 6'd2, rd);  check("R9 hold high readback", 32'(rd), 32'h0F0F);
    bus_rd(6'h1C, rd);           check("R9 unmapped 0x1C", 32'(rd), 32'h0);

    // R2: direction and data
    bus_wr(OF_DIR, 16'h00F0);
    bus_wr(OF_DATA, 16'h00A5);
    bus_wr(OF_DIR + 6'd2, 16'hFFFF);
    bus_wr(OF_DATA + 6'd2, 16'h8001);
    pin_in = 32'h5555_0F0F;
    repeat (3) @(negedge clk);
    check("R2 pin_oe", pin_oe, 32'hFFFF_00F0);
    check("R2 pin_out", pin_out, 32'h8001_00A5);
    bus_rd(OF_DATA, rd);          check("R2 data low mixed read", 32'(rd), 32'h0FAF);
    bus_rd(OF_DATA + 6'd2, rd);   check("R2 data high output read", 32'(rd), 32'h8001);
    bus_wr(OF_DIR, 16'h0000);
    bus_wr(OF_DIR + 6'd2, 16'h0000);
    bus_rd(OF_DATA, rd);          check("R2 data low input read", 32'(rd), 32'h0F0F);
    pin_in = '0;

    // Vector walk over detection modes (R3, R4, R5)
    for (int v = 0; v < NV; v++) begin
      logic [4:0] p;
      logic [15:0] m;
      logic [5:0] hofs;
      p = VEC[v][13:9];
      m = 16'(1) << p[3:0];
      hofs = p[4] ? 6'd2 : 6'd0;
      pin_in = '0;
      repeat (4) @(negedge clk);
      for (int h = 0; h < 2; h++) begin
        logic [15:0] w;
        logic [5:0] ho;
        w = (h == int'(p[4])) ? m : 16'h0;
        ho = 6'(2 * h);
        bus_wr(OF_TYPE + ho, VEC[v][8] ? w : 16'h0);
        bus_wr(OF_LVL  + ho, VEC[v][7] ? w : 16'h0);
        bus_wr(OF_HOLD + ho, VEC[v][6] ? w : 16'h0);
        bus_wr(OF_FALL + ho, VEC[v][5] ? w : 16'h0);
        bus_wr(OF_RISE + ho, VEC[v][4] ? w : 16'h0);
        bus_wr(OF_EN   + ho, w);
      end
      pin_in[p] = VEC[v][3];
      repeat (5) @(negedge clk);
      bus_wr(OF_STAT, 16'hFFFF);
      bus_wr(OF_STAT + 6'd2, 16'hFFFF);
      pin_in[p] = VEC[v][2];
      repeat (3) @(posedge clk);
      @(negedge clk);
      bus_rd(OF_STAT + hofs, rd);
      check($sformatf("R3/R4/R5 vector %0d status now", v), 32'((rd & m) != 0), 32'(VEC[v][1]));
      check($sformatf("R8 vector %0d irq", v), 32'(irq), 32'(VEC[v][1]));
      if (VEC[v][1]) check($sformatf("R8 vector %0d irq_pin", v), 32'(irq_pin), 32'(p));
      repeat (4) @(negedge clk);
      bus_rd(OF_STAT + hofs, rd);
      check($sformatf("R5 vector %0d status late", v), 32'((rd & m) != 0), 32'(VEC[v][0]));
    end

    // Edge-rise-hold on all pins for priority, clear and latency tests
    pin_in = '0;
    for (int h = 0; h < 2; h++) begin
      bus_wr(OF_TYPE + 6'(2*h), 16'hFFFF);
      bus_wr(OF_RISE + 6'(2*h), 16'hFFFF);
      bus_wr(OF_FALL + 6'(2*h), 16'h0000);
      bus_wr(OF_HOLD + 6'(2*h), 16'hFFFF);
      bus_wr(OF_EN   + 6'(2*h), 16'hFFFF);
    end
    repeat (4) @(negedge clk);
    bus_wr(OF_STAT, 16'hFFFF);
    bus_wr(OF_STAT + 6'd2, 16'hFFFF);
    check("R8 idle irq low", 32'(irq), 32'h0);

    // R8: priority
    pin_in[17] = 1'b1; pin_in[18] = 1'b1;
    repeat (3) @(posedge clk); @(negedge clk);
    check("R8 high-half lowest pin", 32'(irq_pin), 32'd17);
    check("R8 irq_valid set", 32'(irq_valid), 32'h1);
    pin_in[9] = 1'b1;
    repeat (3) @(posedge clk); @(negedge clk);
    check("R8 low half before high half", 32'(irq_pin), 32'd9);
    bus_wr(OF_EN, 16'h0000);
    check("R8 low enable off falls back", 32'(irq_pin), 32'd17);
    bus_wr(OF_EN + 6'd2, 16'h0000);
    check("R8 no enable no irq", 32'(irq), 32'h0);
    check("R8 no enable no valid", 32'(irq_valid), 32'h0);
    bus_rd(OF_STAT + 6'd2, rd);
    check("R8 status kept while disabled", 32'(rd), 32'h0006);

    // R6: write-one-to-clear
    pin_in[3] = 1'b1; pin_in[5] = 1'b1;
    repeat (3) @(posedge clk); @(negedge clk);
    bus_rd(OF_STAT, rd);  check("R6 status before clear", 32'(rd), 32'h0228);
    bus_wr(OF_STAT, 16'h0008);
    bus_rd(OF_STAT, rd);  check("R6 one clears only its bit", 32'(rd), 32'h0220);
    bus_wr(OF_STAT, 16'h0000);
    bus_rd(OF_STAT, rd);  check("R6 zero write no change", 32'(rd), 32'h0220);
    bus_wr(OF_STAT + 6'd2, 16'h0002);
    bus_rd(OF_STAT + 6'd2, rd);  check("R6 high half clear", 32'(rd), 32'h0004);

    // R7: latency from pin change to status
    pin_in[12] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    bus_rd(OF_STAT, rd);  check("R7 not yet after two edges", 32'((rd >> 12) & 1), 32'h0);
    @(posedge clk); @(negedge clk);
    bus_rd(OF_STAT, rd);  check("R7 set after third edge", 32'((rd >> 12) & 1), 32'h1);

    done = 1'b1;
    report();
  end
endmodule